// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch stage and guesses, in the same cycle as the fetch, whether a branch will be taken and where it goes. It keeps a direct-mapped branch target cache of 128 entries. Each entry holds a tag, a valid bit, a stored target and a 2-bit saturating direction counter. When the fetch address hits a valid entry, that entry's counter picks the direction and its stored target is returned.

When the cache misses, a static rule based on the decoded branch offset takes over. Backward branches (negative offset) are predicted taken, which suits loops. Forward branches are predicted not taken. The target in that case is the fetch address plus the offset.

The resolve stage reports each branch's real outcome and target. From that report the block trains the counter of a matching entry, or allocates a fresh entry when a branch that missed turns out to be taken.

Top module: `bpred_top`

## Requirements
- R1: After `rst_ni` is released, every entry is invalid, so every lookup misses (`pred_hit_o` = 0) until an entry is allocated.
- R2: The cache is direct-mapped. Address bits [8:2] select the entry and bits [31:9] form the tag. A lookup hits only when the entry is valid and its tag matches. An allocation for a different tag at the same index replaces the old entry.
- R3: On a miss, with `fetch_valid_i` and `fetch_is_br_i` high, `pred_taken_o` equals bit 31 of `fetch_off_i`. A negative offset predicts taken and a zero or positive offset predicts not taken.
- R4: On a miss, `pred_target_o` equals `fetch_pc_i + fetch_off_i`, modulo 2^32.
- R5: On a hit, the direction is bit 1 of the entry's counter. Counter values 2'b10 and 2'b11 predict taken, and 2'b00 and 2'b01 predict not taken.
- R6: On a hit, `pred_target_o` is the target stored in the entry.
- R7: A resolve report whose address misses allocates an entry only when `upd_taken_i` is 1. The new entry's counter starts at 2'b10 and it stores `upd_target_i`. A not-taken report that misses leaves the cache unchanged.
- R8: A resolve report whose address hits moves that entry's counter up by one if taken and down by one if not taken. The counter saturates at 2'b11 and 2'b00. A taken report also overwrites the stored target, and a not-taken report keeps the stored target.
- R9: A lookup in the same cycle as a resolve report to the same index sees the cache as it was before that report. The report's effect is visible to lookups from the next cycle on.
- R10: `pred_taken_o` is 0 whenever `fetch_valid_i` or `fetch_is_br_i` is 0. `pred_hit_o` is 0 whenever `fetch_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A lookup is presented this cycle |
| fetch_pc_i | input | 32 | Fetch address to look up |
| fetch_is_br_i | input | 1 | Decode marks the fetched instruction as a branch |
| fetch_off_i | input | 32 | Signed branch offset, two's complement |
| pred_taken_o | output | 1 | Predicted direction |
| pred_target_o | output | 32 | Predicted target address |
| pred_hit_o | output | 1 | The lookup matched a cache entry |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome of the resolved branch |
| upd_target_i | input | 32 | Actual target of the resolved branch |

## Verification
All three prediction outputs are combinational in the fetch inputs, so each is due in the same cycle as the lookup. A resolve report changes the cache at the next rising edge, so its effect is due in the lookup one cycle later. The bench drives every input at the falling edge and samples the outputs 5 ns later, still before the next rising edge. Each table row that carries a report spends one cycle on the report alone and checks the lookup in the following cycle. The same-cycle case drives the report and the lookup together and checks them twice: once before the edge, where the lookup must still see the old state, and once a cycle after it.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;
endpackage

// File: rtl/bpred_ctr.sv
module bpred_ctr
  import bpred_pkg::*;
(
  input  ctr_e ctr_i,
  input  logic taken_i,
  output ctr_e ctr_o
);
  always_comb begin
    ctr_o = ctr_i;
    if (taken_i) begin
      if (ctr_i != CTR_ST) ctr_o = ctr_e'(ctr_i + 2'd1);
    end else begin
      if (ctr_i != CTR_SNT) ctr_o = ctr_e'(ctr_i - 2'd1);
    end
  end
endmodule

// File: rtl/bpred_static.sv
module bpred_static #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  // backward branch -> taken
  assign taken_o  = off_i[ADDR_W-1];
  assign target_o = pc_i + off_i;
endmodule

// File: rtl/bpred_btac.sv
module bpred_btac
  import bpred_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128,
  parameter int IDX_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // lookup port
  input  logic [ADDR_W-1:0] rd_pc_i,
  output logic              rd_hit_o,
  output ctr_e              rd_ctr_o,
  output logic [ADDR_W-1:0] rd_tgt_o,
  // probe port for the update path
  input  logic [ADDR_W-1:0] up_pc_i,
  output logic              up_hit_o,
  output ctr_e              up_ctr_o,
  // write port
  input  logic              wr_en_i,
  input  ctr_e              wr_ctr_i,
  input  logic              wr_tgt_en_i,
  input  logic [ADDR_W-1:0] wr_tgt_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - IDX_LSB;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  ctr_e               ctr_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];

  logic [IDX_W-1:0] rd_idx, up_idx;
  logic [TAG_W-1:0] rd_tag, up_tag;

  assign rd_idx = rd_pc_i[IDX_LSB +: IDX_W];
  assign rd_tag = rd_pc_i[ADDR_W-1 -: TAG_W];
  assign up_idx = up_pc_i[IDX_LSB +: IDX_W];
  assign up_tag = up_pc_i[ADDR_W-1 -: TAG_W];

  logic unused_lsb;
  assign unused_lsb = ^{rd_pc_i[IDX_LSB-1:0], up_pc_i[IDX_LSB-1:0]};

  assign rd_hit_o = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_ctr_o = ctr_q[rd_idx];
  assign rd_tgt_o = tgt_q[rd_idx];
  assign up_hit_o = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign up_ctr_o = ctr_q[up_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (up_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q[g] <= 1'b0;
      else if (sel) valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[g] <= up_tag;
        ctr_q[g] <= wr_ctr_i;
        if (wr_tgt_en_i) tgt_q[g] <= wr_tgt_i;
      end
    end
  end
endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128,
  parameter int IDX_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              fetch_is_br_i,
  input  logic [ADDR_W-1:0] fetch_off_i,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic              pred_hit_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  logic              rd_hit, up_hit, st_taken;
  ctr_e              rd_ctr, up_ctr, step_ctr, wr_ctr;
  logic [ADDR_W-1:0] rd_tgt, st_tgt;
  logic              wr_en, wr_tgt_en;

  bpred_btac #(
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES),
    .IDX_LSB(IDX_LSB)
  ) u_btac (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_pc_i    (fetch_pc_i),
    .rd_hit_o   (rd_hit),
    .rd_ctr_o   (rd_ctr),
    .rd_tgt_o   (rd_tgt),
    .up_pc_i    (upd_pc_i),
    .up_hit_o   (up_hit),
    .up_ctr_o   (up_ctr),
    .wr_en_i    (wr_en),
    .wr_ctr_i   (wr_ctr),
    .wr_tgt_en_i(wr_tgt_en),
    .wr_tgt_i   (upd_target_i)
  );

  bpred_static #(.ADDR_W(ADDR_W)) u_static (
    .pc_i    (fetch_pc_i),
    .off_i   (fetch_off_i),
    .taken_o (st_taken),
    .target_o(st_tgt)
  );

  bpred_ctr u_ctr (
    .ctr_i  (up_ctr),
    .taken_i(upd_taken_i),
    .ctr_o  (step_ctr)
  );

  // resolve path: train on hit, allocate on taken miss
  always_comb begin
    wr_en     = 1'b0;
    wr_ctr    = step_ctr;
    wr_tgt_en = 1'b0;
    if (upd_valid_i) begin
      if (up_hit) begin
        wr_en     = 1'b1;
        wr_tgt_en = upd_taken_i;
      end else if (upd_taken_i) begin
        wr_en     = 1'b1;
        wr_ctr    = CTR_WT;
        wr_tgt_en = 1'b1;
      end
    end
  end

  // lookup path reads pre-edge state, so a same-cycle write lands after it
  assign pred_hit_o    = fetch_valid_i && rd_hit;
  assign pred_taken_o  = fetch_valid_i && fetch_is_br_i && (rd_hit ? rd_ctr[1] : st_taken);
  assign pred_target_o = rd_hit ? rd_tgt : st_tgt;
endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic [ADDR_W-1:0] fetch_pc_i,
  input logic              fetch_is_br_i,
  input logic [ADDR_W-1:0] fetch_off_i,
  input logic              pred_taken_o,
  input logic [ADDR_W-1:0] pred_target_o,
  input logic              pred_hit_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic              upd_taken_i,
  input logic [ADDR_W-1:0] upd_target_i
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> (!pred_taken_o && !pred_hit_o));

  p_nonbranch_nt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_is_br_i |-> !pred_taken_o);

  p_static_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_is_br_i && !pred_hit_o) |-> (pred_taken_o == fetch_off_i[ADDR_W-1]));

  p_static_tgt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !pred_hit_o) |-> (pred_target_o == fetch_pc_i + fetch_off_i));

  p_taken_seen_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(upd_valid_i && upd_taken_i) && fetch_valid_i && (fetch_pc_i == $past(upd_pc_i)))
      |-> (pred_hit_o && (pred_target_o == $past(upd_target_i))));
endmodule

bind bpred_top bpred_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_valid_i(fetch_valid_i),
  .fetch_pc_i   (fetch_pc_i),
  .fetch_is_br_i(fetch_is_br_i),
  .fetch_off_i  (fetch_off_i),
  .pred_taken_o (pred_taken_o),
  .pred_target_o(pred_target_o),
  .pred_hit_o   (pred_hit_o),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i),
  .upd_target_i (upd_target_i)
);

// File: tb/tb_bpred_top.sv
module tb_bpred_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        fetch_is_br_i = 1'b0;
  logic [31:0] fetch_off_i = '0;
  logic        pred_taken_o;
  logic [31:0] pred_target_o;
  logic        pred_hit_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [31:0] upd_target_i = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  bpred_top dut (.*);

  typedef struct packed {
    logic [7:0]  rq;
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utg;
    logic [31:0] fpc;
    logic        fbr;
    logic [31:0] foff;
    logic        eh;
    logic        et;
    logic [31:0] etg;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_1000;  // index 0
  localparam logic [31:0] PB = 32'h0000_1200;  // index 0, other tag
  localparam logic [31:0] PC = 32'h0000_0040;  // index 16
  localparam logic [31:0] NEG16 = 32'hFFFF_FFF0;
  localparam logic [31:0] NEG8  = 32'hFFFF_FFF8;
  localparam logic [31:0] JUNK  = 32'hDEAD_0000;

  localparam vec_t VECS [16] = '{
    '{8'd3, 1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b1, NEG16, 1'b0, 1'b1, 32'h0000_0FF0}, // R3 R4 backward miss
    '{8'd3, 1'b0, 32'h0, 1'b0, 32'h0, PA, 1'b1, 32'd32, 1'b0, 1'b0, 32'h0000_1020}, // R3 forward miss
    '{8'd7, 1'b1, PA, 1'b0, JUNK, PA, 1'b1, 32'd32, 1'b0, 1'b0, 32'h0000_1020},     // R7 NT miss no alloc
    '{8'd7, 1'b1, PA, 1'b1, 32'h2000, PA, 1'b1, 32'd32, 1'b1, 1'b1, 32'h2000},      // R7 R5 R6 alloc at 10
    '{8'd8, 1'b1, PA, 1'b0, JUNK, PA, 1'b1, 32'd32, 1'b1, 1'b0, 32'h2000},          // R8 -> 01, tgt kept
    '{8'd8, 1'b1, PA, 1'b0, JUNK, PA, 1'b1, 32'd32, 1'b1, 1'b0, 32'h2000},          // R8 -> 00
    '{8'd8, 1'b1, PA, 1'b0, JUNK, PA, 1'b1, 32'd32, 1'b1, 1'b0, 32'h2000},          // R8 stays 00
    '{8'd8, 1'b1, PA, 1'b1, 32'h2000, PA, 1'b1, 32'd32, 1'b1, 1'b0, 32'h2000},      // R8 -> 01
    '{8'd5, 1'b1, PA, 1'b1, 32'h2000, PA, 1'b1, 32'd32, 1'b1, 1'b1, 32'h2000},      // R5 -> 10
    '{8'd5, 1'b1, PA, 1'b1, 32'h2000, PA, 1'b1, 32'd32, 1'b1, 1'b1, 32'h2000},      // R5 -> 11
    '{8'd8, 1'b1, PA, 1'b1, 32'h2000, PA, 1'b1, 32'd32, 1'b1, 1'b1, 32'h2000},      // R8 stays 11
    '{8'd8, 1'b1, PA, 1'b0, JUNK, PA, 1'b1, 32'd32, 1'b1, 1'b1, 32'h2000},          // R8 11 -> 10
    '{8'd2, 1'b0, 32'h0, 1'b0, 32'h0, PB, 1'b1, NEG8, 1'b0, 1'b1, 32'h0000_11F8},   // R2 tag mismatch
    '{8'd2, 1'b1, PB, 1'b1, 32'h3000, PA, 1'b1, 32'd32, 1'b0, 1'b0, 32'h0000_1020}, // R2 replaced
    '{8'd6, 1'b1, PB, 1'b1, 32'h3400, PB, 1'b1, NEG8, 1'b1, 1'b1, 32'h3400},        // R6 R8 tgt rewrite
    '{8'd10, 1'b0, 32'h0, 1'b0, 32'h0, PB, 1'b0, NEG8, 1'b1, 1'b0, 32'h3400}        // R10 not a branch
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] pc, input logic br, input logic [31:0] off);
    fetch_valid_i = 1'b1;
    fetch_pc_i    = pc;
    fetch_is_br_i = br;
    fetch_off_i   = off;
  endtask

  initial begin
    // R1: reset state
    fetch(PA, 1'b1, 32'd32);
    #5;
    chk("R1", "hit in reset", 32'(pred_hit_o), 32'd0);
    fetch_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      string rq;
      @(negedge clk_i);
      rq = $sformatf("R%0d row%0d", VECS[i].rq, i);
      fetch_valid_i = 1'b0;
      if (VECS[i].uv) begin
        upd_valid_i  = 1'b1;
        upd_pc_i     = VECS[i].upc;
        upd_taken_i  = VECS[i].ut;
        upd_target_i = VECS[i].utg;
        @(negedge clk_i);
        upd_valid_i = 1'b0;
      end
      fetch(VECS[i].fpc, VECS[i].fbr, VECS[i].foff);
      #5;
      chk(rq, "hit", 32'(pred_hit_o), 32'(VECS[i].eh));
      chk(rq, "taken", 32'(pred_taken_o), 32'(VECS[i].et));
      chk(rq, "target", pred_target_o, VECS[i].etg);
    end

    // R10: no valid fetch
    @(negedge clk_i);
    fetch(PB, 1'b1, NEG8);
    fetch_valid_i = 1'b0;
    #5;
    chk("R10", "hit idle", 32'(pred_hit_o), 32'd0);
    chk("R10", "taken idle", 32'(pred_taken_o), 32'd0);

    // R9: same-cycle update and lookup, same index
    @(negedge clk_i);
    fetch(PC, 1'b1, 32'd12);
    upd_valid_i  = 1'b1;
    upd_pc_i     = PC;
    upd_taken_i  = 1'b1;
    upd_target_i = 32'h5000;
    #5;
    chk("R9", "hit same cycle", 32'(pred_hit_o), 32'd0);
    chk("R9", "taken same cycle", 32'(pred_taken_o), 32'd0);
    chk("R9", "target same cycle", pred_target_o, 32'h0000_004C);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    #5;
    chk("R9", "hit next cycle", 32'(pred_hit_o), 32'd1);
    chk("R7", "taken after alloc", 32'(pred_taken_o), 32'd1);
    chk("R9", "target next cycle", pred_target_o, 32'h5000);

    // R1: mid-run reset clears the cache
    @(negedge clk_i);
    fetch_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    fetch(PB, 1'b1, NEG8);
    #5;
    chk("R1", "hit after reset", 32'(pred_hit_o), 32'd0);
    chk("R1", "taken after reset", 32'(pred_taken_o), 32'd1);
    chk("R1", "target after reset", pred_target_o, 32'h0000_11F8);
    fetch(PC, 1'b1, 32'd12);
    #2;
    chk("R1", "second entry after reset", 32'(pred_hit_o), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule